// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects an internal 32-bit request port to an asynchronous external memory bus. That bus time-shares 16 pins between address and data. Four fixed address windows each own one active-low chip-select line. An access that lands in an enabled window runs a fixed bus cycle in five steps:

- an address phase, in which an address-latch strobe lets an external latch capture the low address bits from the shared pins;
- a one-cycle hold, in which the address stays on the pins after the strobe drops;
- a data phase of fixed length, with the read or write strobe held low;
- a completion cycle, in which the requester sees a one-cycle ready pulse;
- a return to idle.

Each window is set independently as a 16-bit-wide or a byte-wide memory. For byte-wide memory the controller drives a 17th address line, so that the whole 128 kB window can be reached. For 16-bit memory the address on the pins is a halfword address. High and low byte-enable lines select the lanes that take part in the access.

A global enable gates the whole port. Three kinds of access finish at once with an error and move no bus pin: an access outside the four windows, an access to a disabled window, and any access while the port is disabled. The requester raises `req_valid` with the request fields held stable. It keeps them until it sees `rsp_ready`, and then drops `req_valid`.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is asserted and after it, until a request is accepted, all selects, strobes and byte enables are high (inactive). The address-latch strobe, the 17th address line, the pin drive enable and `rsp_ready` are low.
- R2: Window k (k = 0..3) covers addresses whose top nibble is k+1 and whose bits [27:17] are zero. An accepted hit pulls exactly `ms_n[k]` low, from the address cycle through the last data cycle.
- R3: Address timing. In the cycle after acceptance, `ae` is high for exactly one cycle while the pins drive the address field with the pin drive enable high. In the next cycle `ae` is low and the same address field is still driven.
- R4: Address mapping. For a 16-bit window the address field is addr[16:1] and `a16` is 0. For a byte-wide window the address field is addr[15:0] and `a16` equals addr[16], held from the address cycle through the data phase.
- R5: The data phase lasts WAIT_CYCLES cycles (default 3), with `ws_n` low for a write or `rs_n` low for a read, never both. A write drives the write data with the drive enable high: all 16 bits for a 16-bit window, or the low byte with the upper byte zero for a byte-wide window. A read releases the pins (drive enable low).
- R6: Read data is taken from `ad_in` in the last data-phase cycle only. It appears on `rsp_rdata` in the completion cycle: as is for a 16-bit window, and as the low byte zero-extended for a byte-wide window.
- R7: Byte enables are active only in the data phase. A 16-bit write uses `req_be` (bit 0 for the low lane, which drives `ble_n` low; bit 1 for the high lane, which drives `bhe_n` low). A 16-bit read enables both lanes. A byte-wide access enables only the low lane.
- R8: `rsp_ready` is a one-cycle pulse in the cycle after the last data cycle, with `rsp_err` low. It is low in every other cycle of the access.
- R9: Three kinds of access complete with `rsp_ready` and `rsp_err` both high in the cycle after acceptance, with no select, strobe or `ae` activity: an access outside the windows, an access to a window whose `cfg_region_en` bit is 0, and any access while `cfg_enable` is 0.
- R10: In the cycle after the ready pulse the bus is idle again: `rsp_ready` low, all selects high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Global port enable |
| cfg_region_en | input | 4 | Per-window enable |
| cfg_region_byte | input | 4 | Per-window byte-wide memory flag |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables for 16-bit writes (bit 1 high lane) |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a decode error |
| rsp_rdata | output | 16 | Read data, valid with ready |
| ad_out | output | 16 | Shared address/data pins, driven value |
| ad_oe | output | 1 | Drive enable for the shared pins |
| ad_in | input | 16 | Shared pins, received value |
| a16 | output | 1 | Extra address line for byte-wide memory |
| ms_n | output | 4 | Active-low window selects |
| ae | output | 1 | Address-latch strobe |
| rs_n | output | 1 | Active-low read strobe |
| ws_n | output | 1 | Active-low write strobe |
| bhe_n | output | 1 | Active-low high byte enable |
| ble_n | output | 1 | Active-low low byte enable |

## Verification
A sequencer stuck in or skipping a phase shows within one cycle at the pins: `ae` lasting two cycles, a missing hold cycle, or a data strobe that is one cycle short or long. A wrongly latched window or width flag shows at once, in the address cycle, as the wrong select line or the wrong address field and `a16`. A bad sampling point for read data only shows in `rsp_rdata` at completion. The bench therefore drives a different value on `ad_in` in every data cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HOLD,
    ST_DATA,
    ST_DONE
  } xbus_state_e;

endpackage

// File: rtl/xbus_rst_sync.sv
module xbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/xbus_region_dec.sv
module xbus_region_dec #(
  parameter int REGIONS  = 4,
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 17
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               glob_en,
  input  logic [REGIONS-1:0] region_en,
  output logic [REGIONS-1:0] sel,
  output logic               hit
);

  localparam int TAG_W = 4;
  localparam int MID_HI = ADDR_W - TAG_W - 1;

  logic [TAG_W-1:0] tag;
  logic             mid_zero;

  assign tag      = addr[ADDR_W-1 -: TAG_W];
  assign mid_zero = (addr[MID_HI:WIN_BITS] == '0);

  for (genvar r = 0; r < REGIONS; r++) begin : g_win
    logic in_win;
    assign in_win = (tag == TAG_W'(r + 1)) && mid_zero;
    assign sel[r] = in_win && region_en[r] && glob_en;
  end

  assign hit = |sel;

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq import xbus_pkg::*; #(
  parameter int WAIT_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        hit,
  output xbus_state_e state,
  output logic        last_data
);

  localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;

  xbus_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) state_d = hit ? ST_ADDR : ST_DONE;
      end
      ST_ADDR: state_d = ST_HOLD;
      ST_HOLD: begin
        state_d = ST_DATA;
        cnt_d   = CNT_W'(WAIT_CYCLES - 1);
        cnt_en  = 1'b1;
      end
      ST_DATA: begin
        if (cnt_q == '0) begin
          state_d = ST_DONE;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state     = state_q;
  assign last_data = (state_q == ST_DATA) && (cnt_q == '0);

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins import xbus_pkg::*; #(
  parameter int REGIONS = 4,
  parameter int AD_W    = 16
) (
  input  xbus_state_e        state,
  input  logic [AD_W:0]      lat_addr,
  input  logic [AD_W-1:0]    lat_wdata,
  input  logic               lat_write,
  input  logic [1:0]         lat_be,
  input  logic               lat_byte,
  input  logic [REGIONS-1:0] lat_sel,
  output logic [AD_W-1:0]    ad_out,
  output logic               ad_oe,
  output logic               a16,
  output logic [REGIONS-1:0] ms_n,
  output logic               ae,
  output logic               rs_n,
  output logic               ws_n,
  output logic               bhe_n,
  output logic               ble_n
);

  localparam int HALF = AD_W / 2;

  logic in_addr, in_data, in_bus;
  logic [AD_W-1:0] addr_field, wr_lane;

  assign in_addr = (state == ST_ADDR) || (state == ST_HOLD);
  assign in_data = (state == ST_DATA);
  assign in_bus  = in_addr || in_data;

  assign addr_field = lat_byte ? lat_addr[AD_W-1:0] : lat_addr[AD_W:1];
  assign wr_lane    = lat_byte ? {{(AD_W-HALF){1'b0}}, lat_wdata[HALF-1:0]} : lat_wdata;

  always_comb begin
    if (in_addr)                    ad_out = addr_field;
    else if (in_data && lat_write)  ad_out = wr_lane;
    else                            ad_out = '0;
  end

  assign ad_oe = in_addr || (in_data && lat_write);
  assign ae    = (state == ST_ADDR);
  assign a16   = in_bus && lat_byte && lat_addr[AD_W];
  assign ms_n  = in_bus ? ~lat_sel : '1;
  assign rs_n  = ~(in_data && !lat_write);
  assign ws_n  = ~(in_data && lat_write);

  always_comb begin
    bhe_n = 1'b1;
    ble_n = 1'b1;
    if (in_data) begin
      if (lat_byte) begin
        ble_n = 1'b0;
      end else if (lat_write) begin
        ble_n = ~lat_be[0];
        bhe_n = ~lat_be[1];
      end else begin
        ble_n = 1'b0;
        bhe_n = 1'b0;
      end
    end
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl import xbus_pkg::*; #(
  parameter int REGIONS     = 4,
  parameter int AD_W        = 16,
  parameter int ADDR_W      = 32,
  parameter int WAIT_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic [REGIONS-1:0] cfg_region_en,
  input  logic [REGIONS-1:0] cfg_region_byte,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [AD_W-1:0]    req_wdata,
  input  logic [1:0]         req_be,
  output logic               rsp_ready,
  output logic               rsp_err,
  output logic [AD_W-1:0]    rsp_rdata,
  output logic [AD_W-1:0]    ad_out,
  output logic               ad_oe,
  input  logic [AD_W-1:0]    ad_in,
  output logic               a16,
  output logic [REGIONS-1:0] ms_n,
  output logic               ae,
  output logic               rs_n,
  output logic               ws_n,
  output logic               bhe_n,
  output logic               ble_n
);

  localparam int WIN_BITS = AD_W + 1;
  localparam int HALF     = AD_W / 2;

  logic               rst_i_n;
  xbus_state_e        state;
  logic               last_data;
  logic               accept;
  logic               hit;
  logic [REGIONS-1:0] sel;

  logic [AD_W:0]      lat_addr;
  logic [AD_W-1:0]    lat_wdata;
  logic               lat_write;
  logic [1:0]         lat_be;
  logic               lat_byte;
  logic [REGIONS-1:0] lat_sel;
  logic               err_q;
  logic [AD_W-1:0]    rdata_q, rdata_d;

  xbus_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  xbus_region_dec #(
    .REGIONS  (REGIONS),
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS)
  ) u_dec (
    .addr      (req_addr),
    .glob_en   (cfg_enable),
    .region_en (cfg_region_en),
    .sel       (sel),
    .hit       (hit)
  );

  assign accept = (state == ST_IDLE) && req_valid;

  xbus_seq #(
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (req_valid),
    .hit       (hit),
    .state     (state),
    .last_data (last_data)
  );

  // Request fields captured once, at acceptance.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_write <= 1'b0;
      lat_be    <= '0;
      lat_byte  <= 1'b0;
      lat_sel   <= '0;
      err_q     <= 1'b0;
    end else if (accept) begin
      lat_addr  <= req_addr[AD_W:0];
      lat_wdata <= req_wdata;
      lat_write <= req_write;
      lat_be    <= req_be;
      lat_byte  <= |(sel & cfg_region_byte);
      lat_sel   <= sel;
      err_q     <= !hit;
    end
  end

  assign rdata_d = lat_byte ? {{(AD_W-HALF){1'b0}}, ad_in[HALF-1:0]} : ad_in;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)       rdata_q <= '0;
    else if (last_data) rdata_q <= rdata_d;
  end

  xbus_pins #(
    .REGIONS (REGIONS),
    .AD_W    (AD_W)
  ) u_pins (
    .state     (state),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .lat_write (lat_write),
    .lat_be    (lat_be),
    .lat_byte  (lat_byte),
    .lat_sel   (lat_sel),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .a16       (a16),
    .ms_n      (ms_n),
    .ae        (ae),
    .rs_n      (rs_n),
    .ws_n      (ws_n),
    .bhe_n     (bhe_n),
    .ble_n     (ble_n)
  );

  assign rsp_ready = (state == ST_DONE);
  assign rsp_err   = (state == ST_DONE) && err_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int REGIONS = 4,
  parameter int AD_W    = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rsp_ready,
  input logic               rsp_err,
  input logic [AD_W-1:0]    ad_out,
  input logic               ad_oe,
  input logic [REGIONS-1:0] ms_n,
  input logic               ae,
  input logic               rs_n,
  input logic               ws_n,
  input logic               bhe_n,
  input logic               ble_n
);

  assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ms_n) <= 1);

  assert_ae_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ae |=> !ae);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ae) |-> ($stable(ad_out) && ad_oe && $stable(ms_n)));

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rs_n && !ws_n));

  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_n |-> !ad_oe);

  assert_lane_in_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bhe_n || !ble_n) |-> (!rs_n || !ws_n));

  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_ready && (&ms_n) && !ae && rs_n && ws_n));

endmodule

bind xbus_ctrl xbus_ctrl_chk #(
  .REGIONS (REGIONS),
  .AD_W    (AD_W)
) i_xbus_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rsp_ready (rsp_ready),
  .rsp_err   (rsp_err),
  .ad_out    (ad_out),
  .ad_oe     (ad_oe),
  .ms_n      (ms_n),
  .ae        (ae),
  .rs_n      (rs_n),
  .ws_n      (ws_n),
  .bhe_n     (bhe_n),
  .ble_n     (ble_n)
);

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;

  localparam int W = 3;

  logic        clk;
  logic        rst_n;
  logic        cfg_enable;
  logic [3:0]  cfg_region_en;
  logic [3:0]  cfg_region_byte;
  logic        req_valid;
  logic        req_write;
  logic [31:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_ready;
  logic        rsp_err;
  logic [15:0] rsp_rdata;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [15:0] ad_in;
  logic        a16;
  logic [3:0]  ms_n;
  logic        ae;
  logic        rs_n;
  logic        ws_n;
  logic        bhe_n;
  logic        ble_n;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  xbus_ctrl #(.WAIT_CYCLES(W)) i_xbus_ctrl (
    .clk (clk), .rst_n (rst_n),
    .cfg_enable (cfg_enable), .cfg_region_en (cfg_region_en),
    .cfg_region_byte (cfg_region_byte),
    .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
    .req_wdata (req_wdata), .req_be (req_be),
    .rsp_ready (rsp_ready), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata),
    .ad_out (ad_out), .ad_oe (ad_oe), .ad_in (ad_in), .a16 (a16),
    .ms_n (ms_n), .ae (ae), .rs_n (rs_n), .ws_n (ws_n),
    .bhe_n (bhe_n), .ble_n (ble_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d cycles exp=completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] drive_val(input int i, input logic [31:0] a);
    return 16'hA5C3 ^ (16'(i + 1) * 16'h1357) ^ a[15:0];
  endfunction

  task automatic access(input logic [31:0] a, input bit wr, input logic [15:0] wd,
                        input logic [1:0] be);
    int          tagv;
    bit          exp_hit;
    bit          bm;
    logic [3:0]  exp_ms;
    logic [15:0] exp_ad;
    logic        exp_a16;
    logic [15:0] exp_wd;
    logic        exp_ble, exp_bhe;
    logic [15:0] lastv;
    tagv    = int'(a[31:28]);
    exp_hit = cfg_enable && tagv >= 1 && tagv <= 4 && a[27:17] == 0 &&
              cfg_region_en[tagv-1];
    bm      = exp_hit ? cfg_region_byte[tagv-1] : 1'b0;
    exp_ms  = exp_hit ? ~(4'b0001 << (tagv - 1)) : 4'hF;
    exp_ad  = bm ? a[15:0] : a[16:1];
    exp_a16 = bm ? a[16] : 1'b0;
    exp_wd  = bm ? {8'h00, wd[7:0]} : wd;
    exp_ble = bm ? 1'b0 : (wr ? ~be[0] : 1'b0);
    exp_bhe = bm ? 1'b1 : (wr ? ~be[1] : 1'b0);
    lastv   = '0;

    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    @(negedge clk);
    if (!exp_hit) begin
      chk(rsp_ready && rsp_err, "R9 miss completes at once with error",
          {rsp_ready, rsp_err}, 2'b11);
      chk(ms_n == 4'hF && !ae && rs_n && ws_n, "R9 miss moves no pin",
          {ms_n, ae, rs_n, ws_n}, {4'hF, 1'b0, 1'b1, 1'b1});
    end else begin
      chk(ae && ad_oe && ad_out == exp_ad, "R3 address cycle",
          {ae, ad_oe, ad_out}, {1'b1, 1'b1, exp_ad});
      chk(ms_n == exp_ms, "R2 select in address cycle", ms_n, exp_ms);
      chk(a16 == exp_a16, "R4 a16 in address cycle", a16, exp_a16);
      chk(!rsp_ready, "R8 no ready in address cycle", rsp_ready, 0);
      @(negedge clk);
      chk(!ae && ad_oe && ad_out == exp_ad && ms_n == exp_ms, "R3 hold cycle",
          {ae, ad_oe, ad_out, ms_n}, {1'b0, 1'b1, exp_ad, exp_ms});
      for (int i = 0; i < W; i++) begin
        @(negedge clk);
        ad_in = drive_val(i, a);
        lastv = ad_in;
        chk(rs_n == wr && ws_n == !wr, "R5 strobe in data phase",
            {rs_n, ws_n}, {wr, !wr});
        chk(ad_oe == wr, "R5 pin drive in data phase", ad_oe, wr);
        if (wr) chk(ad_out == exp_wd, "R5 write data on pins", ad_out, exp_wd);
        chk(ble_n == exp_ble && bhe_n == exp_bhe, "R7 byte enables",
            {bhe_n, ble_n}, {exp_bhe, exp_ble});
        chk(ms_n == exp_ms && a16 == exp_a16, "R2 R4 select and a16 in data",
            {ms_n, a16}, {exp_ms, exp_a16});
        chk(!rsp_ready && !ae, "R8 no ready in data phase", {rsp_ready, ae}, 0);
      end
      @(negedge clk);
      chk(rsp_ready && !rsp_err, "R8 ready pulse after data",
          {rsp_ready, rsp_err}, 2'b10);
      chk(rs_n && ws_n && bhe_n && ble_n, "R5 R7 strobes released at done",
          {rs_n, ws_n, bhe_n, ble_n}, 4'hF);
      if (!wr) begin
        logic [15:0] er;
        er = bm ? {8'h00, lastv[7:0]} : lastv;
        chk(rsp_rdata == er, "R6 read data from last data cycle", rsp_rdata, er);
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(!rsp_ready && ms_n == 4'hF && !ae, "R10 idle after ready",
        {rsp_ready, ms_n, ae}, {1'b0, 4'hF, 1'b0});
  endtask

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b0; cfg_region_en = '0; cfg_region_byte = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    req_be = '0; ad_in = '0;
    repeat (3) @(negedge clk);
    chk(ms_n == 4'hF && rs_n && ws_n && bhe_n && ble_n && !ae && !a16 &&
        !ad_oe && !rsp_ready, "R1 outputs in reset",
        {ms_n, rs_n, ws_n, bhe_n, ble_n, ae, a16, ad_oe, rsp_ready},
        {4'hF, 4'hF, 5'h0});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ms_n == 4'hF && rs_n && ws_n && !ae && !rsp_ready, "R1 idle after reset",
        {ms_n, rs_n, ws_n, ae, rsp_ready}, {4'hF, 2'b11, 2'b00});

    for (int ph = 0; ph < 3; ph++) begin
      cfg_enable    = (ph != 2);
      cfg_region_en = (ph == 1) ? 4'b1010 : 4'b1111;
      for (int m = 0; m < 2; m++) begin
        cfg_region_byte = m ? 4'b1010 : 4'b0101;
        for (int t = 0; t < 6; t++) begin
          for (int wr = 0; wr < 2; wr++) begin
            for (int k = 0; k < 5; k++) begin
              logic [31:0] off;
              case (k)
                0: off = 32'h0000_0000;
                1: off = 32'h0001_FFFF;
                2: off = 32'h0001_2345;
                3: off = 32'h0000_ABCE;
                default: off = 32'h0002_0000;
              endcase
              access({4'(t), 28'h0} | off, wr[0],
                     16'h3C00 ^ 16'(t * 16'h0111 + k * 16'h0F0F), 2'(k + 1));
            end
          end
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule